// File: doc/BRIEF.md
# Upstream port failover controller

This block chooses which of two candidate ports acts as the upstream port of a switch, and swaps the role between them on request. At fundamental reset it captures a boot-mode code. Two codes turn failover on: one starts with the first candidate port upstream, the other starts with the second. Any other code leaves failover off, and the first candidate stays upstream for good.

With failover on, a swap can be requested in two ways. One is a change in level, in either direction, on the asynchronous upstream-select pin. The other is a software write of a one to the start bit. An accepted request raises `busy` and emits a one-cycle `swap_req` pulse naming the target, which is always the candidate that is not current. The rest of the switch retrains the links and answers on `fo_done`. In that cycle `busy` falls and the current-upstream status flips. Requests that arrive while `busy` is high are dropped, not queued.

The block also drives a per-port enable vector and a one-hot upstream-role vector. With failover on and the candidate ports bifurcated, the non-current candidate is disabled. All other ports stay enabled.

Top module: `ufo_ctrl`

## Requirements
- R1: On the first rising clock edge after `rst_n` goes high, the block latches `boot_mode`. Code 4'hA gives `fo_mode`=1 with `cur_usp`=0 (port 0). Code 4'hB gives `fo_mode`=1 with `cur_usp`=1 (port 2). Any other code gives `fo_mode`=0 with `cur_usp`=0. Changes to `boot_mode` after that edge have no effect. While in reset, `fo_mode`=0, `busy`=0 and `cur_usp`=0.
- R2: With `fo_mode`=0, select-pin changes and software start writes have no effect: `busy` stays 0, `swap_req` never pulses and `cur_usp` does not change.
- R3: With `fo_mode`=1 and `busy`=0, a level change on `usp_sel` passes through a two-flop synchronizer and an edge detector. `busy` rises at the third rising edge after the change, and not before.
- R4: A cycle with `sw_wr`=1 and `sw_start`=1 sets the start bit. The start bit reads back 1 for exactly one cycle and then clears, whether the request was accepted or dropped. If accepted, `busy` rises at the edge after the bit was set. A write with `sw_start`=0 sets nothing.
- R5: A request from either source is dropped while `busy`=1, including in the cycle that `fo_done` ends the swap. No second swap follows once the first one completes.
- R6: `fo_done`=1 while `busy`=1 clears `busy` and inverts `cur_usp` at the same edge. `fo_done` while `busy`=0 changes nothing.
- R7: Each accepted request produces exactly one single-cycle `swap_req` pulse, at the same edge where `busy` rises. `swap_target` equals the inverse of `cur_usp` at acceptance (0 = port 0, 1 = port 2).
- R8: `port_en` bit i is 0 only when `fo_mode`=1, `bifurcated`=1 and i is the candidate port not named by `cur_usp`. Every other port is enabled.
- R9: `port_up` is one-hot. Its bit is port 0 when `fo_mode`=0, and otherwise the candidate named by `cur_usp`.
- R10: A select level already held through reset and kept steady afterwards produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous |
| boot_mode | input | 4 | Boot-mode code, latched after reset |
| usp_sel | input | 1 | Asynchronous upstream-select pin; any level change requests a swap |
| sw_wr | input | 1 | Software write strobe for the start bit |
| sw_start | input | 1 | Write data for the start bit; 1 requests a swap |
| fo_done | input | 1 | Swap-complete handshake from the rest of the switch |
| bifurcated | input | 1 | The candidate ports run in bifurcated mode |
| fo_mode | output | 1 | Failover was enabled at the last reset |
| cur_usp | output | 1 | Current upstream: 0 = port 0, 1 = port 2 |
| busy | output | 1 | A swap is in progress |
| sw_start_bit | output | 1 | Read-back of the self-clearing start bit |
| swap_req | output | 1 | One-cycle pulse when a swap begins |
| swap_target | output | 1 | New upstream for the pending swap, same encoding as cur_usp |
| port_en | output | 4 | Per-port enable |
| port_up | output | 4 | One-hot upstream role per port |

## Verification
The hardest case to reach is a request that coincides with the `fo_done` cycle. To create it, the stimulus issues a software write one cycle ahead, so that the start bit is live in exactly the edge where `fo_done` is high. A second hard case is a synchronized select edge that lands mid-swap. For that, the select pin is toggled right after acceptance and the swap is held open until the three-cycle synchronizer latency has passed. A scoreboard queue holds the expected swap targets and flags any pulse it did not predict. This makes dropped requests visible at the ports.

// File: rtl/ufo_pkg.sv
package ufo_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } swap_state_t;

  typedef struct packed {
    logic fo_en;     // failover enabled at last reset
    logic init_sel;  // 0: first candidate starts upstream, 1: second
  } boot_cfg_t;

endpackage

// File: rtl/ufo_boot_latch.sv
module ufo_boot_latch
  import ufo_pkg::*;
#(
  parameter int              MODE_W    = 4,
  parameter logic [MODE_W-1:0] CODE_FO_A = 4'hA,
  parameter logic [MODE_W-1:0] CODE_FO_B = 4'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] boot_mode,
  output boot_cfg_t         cfg,
  output logic              captured
);

  boot_cfg_t cfg_next;

  always_comb begin
    cfg_next.fo_en    = (boot_mode == CODE_FO_A) || (boot_mode == CODE_FO_B);
    cfg_next.init_sel = (boot_mode == CODE_FO_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      cfg      <= '0;
    end else if (!captured) begin
      captured <= 1'b1;
      cfg      <= cfg_next;
    end
  end

  // R1: once captured, the configuration never moves until the next reset
  p_boot_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(captured) |-> $stable(cfg));

endmodule

// File: rtl/ufo_sel_sync.sv
module ufo_sel_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_async,
  output logic sel_edge
);

  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int PRIME_W   = $clog2(PRIME_MAX + 1);

  logic [SYNC_STAGES-1:0] stage;
  logic                   sel_prev;
  logic [PRIME_W-1:0]     prime_cnt;
  logic                   primed;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= sel_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= 1'b0;
      prime_cnt <= '0;
    end else begin
      sel_prev <= stage[SYNC_STAGES-1];
      if (!primed) prime_cnt <= prime_cnt + 1'b1;
    end
  end

  // edges are ignored until the whole chain holds real pin samples (R10)
  assign primed   = (prime_cnt == PRIME_W'(PRIME_MAX));
  assign sel_edge = primed && (stage[SYNC_STAGES-1] != sel_prev);

endmodule

// File: rtl/ufo_swap_fsm.sv
module ufo_swap_fsm
  import ufo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  boot_cfg_t cfg,
  input  logic      sel_edge,
  input  logic      sw_wr,
  input  logic      sw_start,
  input  logic      fo_done,
  output logic      cur_sel,
  output logic      busy,
  output logic      sw_pend,
  output logic      swap_req,
  output logic      swap_target
);

  swap_state_t state;
  logic        flip;
  logic        req;
  logic        accept;

  assign cur_sel = cfg.init_sel ^ flip;
  assign busy    = (state == ST_BUSY);
  assign req     = cfg.fo_en && (sel_edge || sw_pend);
  assign accept  = req && (state == ST_IDLE);

  // write-one start bit: it is consumed in the very next cycle either way
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= 1'b0;
    else        sw_pend <= sw_wr && sw_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      flip        <= 1'b0;
      swap_req    <= 1'b0;
      swap_target <= 1'b0;
    end else begin
      swap_req <= accept;
      if (accept) swap_target <= ~cur_sel;
      case (state)
        ST_IDLE: if (accept) state <= ST_BUSY;
        ST_BUSY: if (fo_done) begin
          state <= ST_IDLE;
          flip  <= ~flip;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: without failover no swap can ever begin
  p_nofo_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.fo_en |-> !busy && !swap_req);

  // R5: nothing is started while a swap is open
  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !swap_req);

  // R6: done while busy ends the swap and flips the upstream
  p_done_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fo_done |=> !busy && (cur_sel != $past(cur_sel)));

  // R6: while idle the upstream stays put
  p_cur_stable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.fo_en) && !$past(busy) |-> $stable(cur_sel));

  // R7: pulse is single-cycle and targets the non-current port
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |-> busy && (swap_target != cur_sel) ##1 !swap_req);

  // R4: the start bit never stays set without a fresh write
  p_pend_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pend && !sw_wr |=> !sw_pend);

endmodule

// File: rtl/ufo_port_map.sv
module ufo_port_map #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_A    = 0,
  parameter int PORT_B    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fo_en,
  input  logic                 cur_sel,
  input  logic                 bifurcated,
  output logic [NUM_PORTS-1:0] port_en,
  output logic [NUM_PORTS-1:0] port_up
);

  int up_idx;
  int off_idx;

  always_comb begin
    up_idx  = (fo_en && cur_sel) ? PORT_B : PORT_A;
    off_idx = cur_sel ? PORT_A : PORT_B;
  end

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      assign port_up[i] = (up_idx == i);
      assign port_en[i] = !(fo_en && bifurcated && (off_idx == i));
    end
  endgenerate

  // R9: exactly one upstream role
  p_role_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_up) == 1);

  // R8: the upstream port is never disabled
  p_up_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_up & ~port_en) == '0);

  // R8: at most one port is ever disabled
  p_one_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~port_en) <= 1);

endmodule

// File: rtl/ufo_ctrl.sv
module ufo_ctrl
  import ufo_pkg::*;
#(
  parameter int              MODE_W      = 4,
  parameter logic [MODE_W-1:0] CODE_FO_A   = 4'hA,
  parameter logic [MODE_W-1:0] CODE_FO_B   = 4'hB,
  parameter int              NUM_PORTS   = 4,
  parameter int              PORT_A      = 0,
  parameter int              PORT_B      = 2,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MODE_W-1:0]    boot_mode,
  input  logic                 usp_sel,
  input  logic                 sw_wr,
  input  logic                 sw_start,
  input  logic                 fo_done,
  input  logic                 bifurcated,
  output logic                 fo_mode,
  output logic                 cur_usp,
  output logic                 busy,
  output logic                 sw_start_bit,
  output logic                 swap_req,
  output logic                 swap_target,
  output logic [NUM_PORTS-1:0] port_en,
  output logic [NUM_PORTS-1:0] port_up
);

  boot_cfg_t cfg;
  logic      captured;
  logic      sel_edge;
  logic      cur_sel;

  ufo_boot_latch #(
    .MODE_W(MODE_W), .CODE_FO_A(CODE_FO_A), .CODE_FO_B(CODE_FO_B)
  ) u_boot (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .cfg(cfg), .captured(captured)
  );

  ufo_sel_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_async(usp_sel), .sel_edge(sel_edge)
  );

  ufo_swap_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .sel_edge(sel_edge),
    .sw_wr(sw_wr), .sw_start(sw_start), .fo_done(fo_done),
    .cur_sel(cur_sel), .busy(busy), .sw_pend(sw_start_bit),
    .swap_req(swap_req), .swap_target(swap_target)
  );

  ufo_port_map #(
    .NUM_PORTS(NUM_PORTS), .PORT_A(PORT_A), .PORT_B(PORT_B)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .fo_en(cfg.fo_en), .cur_sel(cur_sel),
    .bifurcated(bifurcated), .port_en(port_en), .port_up(port_up)
  );

  assign fo_mode = cfg.fo_en;
  assign cur_usp = cur_sel;

  // R1: before capture the block reports the safe default
  p_precap_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> !fo_mode && !busy);

endmodule

// File: tb/sim_ufo_ctrl.sv
`timescale 1ns/1ps
module sim_ufo_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] boot_mode = 4'h0;
  logic       usp_sel = 1'b0;
  logic       sw_wr = 1'b0;
  logic       sw_start = 1'b0;
  logic       fo_done = 1'b0;
  logic       bifurcated = 1'b0;
  logic       fo_mode, cur_usp, busy, sw_start_bit, swap_req, swap_target;
  logic [3:0] port_en, port_up;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  ufo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .usp_sel(usp_sel),
    .sw_wr(sw_wr), .sw_start(sw_start), .fo_done(fo_done),
    .bifurcated(bifurcated), .fo_mode(fo_mode), .cur_usp(cur_usp),
    .busy(busy), .sw_start_bit(sw_start_bit), .swap_req(swap_req),
    .swap_target(swap_target), .port_en(port_en), .port_up(port_up)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // monitor: every swap pulse must match the next predicted target (R7, R5)
  always @(negedge clk) begin
    if (rst_n && swap_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected swap_req", 1, 0);
      end else begin
        chk_eq("R7 swap_target", int'(swap_target), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] code, input logic sel_lvl);
    @(negedge clk);
    rst_n = 1'b0;
    boot_mode = code;
    usp_sel = sel_lvl;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic sw_write(input logic bitv);
    sw_wr = 1'b1;
    sw_start = bitv;
    @(negedge clk);
    sw_wr = 1'b0;
    sw_start = 1'b0;
  endtask

  task automatic pulse_done();
    fo_done = 1'b1;
    @(negedge clk);
    fo_done = 1'b0;
  endtask

  task automatic chk_q_empty(input string tag);
    chk_eq(tag, exp_q.size(), 0);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state (R1)
    cyc(2);
    chk_eq("R1 reset fo_mode", int'(fo_mode), 0);
    chk_eq("R1 reset busy", int'(busy), 0);
    chk_eq("R9 reset role", int'(port_up), 1);
    chk_eq("R8 reset enables", int'(port_en), 15);

    // non-failover code: requests ignored (R2)
    do_reset(4'h3, 1'b0);
    chk_eq("R1 code 3 fo_mode", int'(fo_mode), 0);
    usp_sel = 1'b1;
    cyc(5);
    chk_eq("R2 sel ignored busy", int'(busy), 0);
    sw_write(1'b1);
    cyc(3);
    chk_eq("R2 sw ignored busy", int'(busy), 0);
    chk_eq("R2 cur unchanged", int'(cur_usp), 0);
    bifurcated = 1'b1;
    cyc(1);
    chk_eq("R8 nofo all enabled", int'(port_en), 15);
    chk_eq("R9 nofo role port0", int'(port_up), 1);

    // failover starting at port 0
    do_reset(4'hA, 1'b0);
    chk_eq("R1 code A fo_mode", int'(fo_mode), 1);
    chk_eq("R1 code A cur", int'(cur_usp), 0);
    boot_mode = 4'h0;
    cyc(2);
    chk_eq("R1 late boot change ignored", int'(fo_mode), 1);
    chk_eq("R8 bif port2 off", int'(port_en), 4'b1011);
    chk_eq("R9 role port0", int'(port_up), 4'b0001);

    // select toggle timing (R3)
    usp_sel = 1'b1;
    exp_q.push_back(1'b1);
    cyc(2);
    chk_eq("R3 not busy after two edges", int'(busy), 0);
    cyc(1);
    chk_eq("R3 busy after third edge", int'(busy), 1);

    // requests while busy dropped (R5)
    usp_sel = 1'b0;
    sw_write(1'b1);
    cyc(5);
    chk_eq("R5 still busy", int'(busy), 1);
    chk_eq("R6 cur held during swap", int'(cur_usp), 0);
    pulse_done();
    chk_eq("R6 busy cleared", int'(busy), 0);
    chk_eq("R6 cur flipped", int'(cur_usp), 1);
    chk_eq("R8 bif port0 off", int'(port_en), 4'b1110);
    chk_eq("R9 role port2", int'(port_up), 4'b0100);
    cyc(4);
    chk_eq("R5 no later swap busy", int'(busy), 0);
    chk_q_empty("R5 queue drained");

    // done while idle (R6)
    pulse_done();
    cyc(1);
    chk_eq("R6 idle done no flip", int'(cur_usp), 1);

    // software start (R4)
    sw_write(1'b0);
    chk_eq("R4 zero write no bit", int'(sw_start_bit), 0);
    cyc(2);
    chk_eq("R4 zero write no busy", int'(busy), 0);
    sw_wr = 1'b1; sw_start = 1'b1;
    exp_q.push_back(1'b0);
    @(negedge clk);
    sw_wr = 1'b0; sw_start = 1'b0;
    chk_eq("R4 bit reads one", int'(sw_start_bit), 1);
    chk_eq("R4 not busy yet", int'(busy), 0);
    @(negedge clk);
    chk_eq("R4 busy next edge", int'(busy), 1);
    chk_eq("R4 bit cleared", int'(sw_start_bit), 0);

    // request coinciding with done is dropped (R5)
    sw_wr = 1'b1; sw_start = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0; sw_start = 1'b0;
    fo_done = 1'b1;
    @(negedge clk);
    fo_done = 1'b0;
    chk_eq("R6 cur back to port0", int'(cur_usp), 0);
    chk_eq("R5 coincident dropped busy", int'(busy), 0);
    chk_eq("R4 bit cleared after drop", int'(sw_start_bit), 0);
    cyc(3);
    chk_eq("R5 coincident no later busy", int'(busy), 0);
    chk_q_empty("R5 queue after coincident");

    bifurcated = 1'b0;
    cyc(1);
    chk_eq("R8 non-bif all enabled", int'(port_en), 15);

    // failover starting at port 2, select held high through reset (R10)
    do_reset(4'hB, 1'b1);
    chk_eq("R1 code B cur", int'(cur_usp), 1);
    chk_eq("R9 code B role", int'(port_up), 4'b0100);
    cyc(4);
    chk_eq("R10 held level no request", int'(busy), 0);
    usp_sel = 1'b0;
    exp_q.push_back(1'b0);
    cyc(3);
    chk_eq("R3 falling change accepted", int'(busy), 1);
    pulse_done();
    chk_eq("R6 code B flip to port0", int'(cur_usp), 0);
    cyc(2);
    chk_q_empty("R7 all pulses seen");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule